// File: doc/BRIEF.md
# ARINC 429 Receive Channel with Label Filter

This block takes one ARINC 429 receive line that has already been turned into two logic signals. One signal is high while the line sits at the positive level, and the other is high while it sits at the negative level. The block rebuilds each 32-bit word from these signals. When filtering is on, it drops every word whose label is not in a small programmable table. Accepted words wait in a 32-entry queue, and a host reads them over a 16-bit bus in two steps. All bit timing counts cycles of the block clock, which is taken to be a 1 MHz reference. One input selects between two data rates.

The host loads the label table through its own sequence. While that sequence runs, reception is paused and any word in flight is lost. A separate request turns the next sixteen host reads into a read-back of the table, and these reads leave the queue untouched. Three flags show the queue state: data ready, half full and full.

Top module: `a429_rx_filter`

## Requirements
- R1: After reset, `data_rdy`, `half_full` and `full` are low.
- R2: A bit reads as ONE when only `line_hi` is high, as ZERO when only `line_lo` is high, and as NULL when both are low. The bit period is 10 clocks when `rate_slow`=0 and 80 clocks when `rate_slow`=1. Each bit is sampled a quarter period after the clock in which the line leaves NULL. The first bit received lands in word bit 0.
- R3: A word is complete when 32 bits have been sampled and no new bit starts within 1.5 bit periods of the start of the last bit. A complete word is then offered to the queue.
- R4: The block discards a word in three cases: a bit is sampled with both inputs high, the NULL gap comes before 32 bits, or a 33rd bit starts. A discarded word leaves nothing in the queue.
- R5: When `filt_en`=0, every complete word is stored. When `filt_en`=1, a word is stored only if its bits [7:0] equal one of the table entries written since the last rise of `lbl_load`.
- R6: While `lbl_load` is high, reception is suspended, so a word in progress or sent during that time is not stored. Each `lbl_wr` pulse stores `lbl_wdata` in the next slot, starting at slot 0 on each rise of `lbl_load`. Writes after the 16th are ignored, and slots not rewritten keep their old contents.
- R7: A `lbl_dump` pulse makes the next 16 `rd_stb` pulses present `{8'h00, slot k}` on `rd_data`, for k = 0 to 15 in order. These reads do not remove anything from the queue.
- R8: `rd_data` shows bits [15:0] of the oldest word. After one `rd_stb` it shows bits [31:16]. The second `rd_stb` removes the word. An `rd_stb` while the queue is empty has no effect.
- R9: The queue holds 32 words and returns them in arrival order. A word completed while the queue is full is dropped.
- R10: `data_rdy` is high when the queue holds at least one word, `half_full` when it holds 16 or more, and `full` when it holds 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1 MHz timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_hi | input | 1 | Line at positive level |
| line_lo | input | 1 | Line at negative level |
| rate_slow | input | 1 | 1 selects 12.5 kbit/s, 0 selects 100 kbit/s |
| filt_en | input | 1 | Enable label filtering |
| lbl_load | input | 1 | Label table load mode (suspends reception) |
| lbl_wr | input | 1 | Write strobe for the next table slot |
| lbl_wdata | input | 8 | Label to write |
| lbl_dump | input | 1 | Arm a 16-read table read-back |
| rd_stb | input | 1 | Host read strobe |
| rd_data | output | 16 | Host read data |
| data_rdy | output | 1 | Queue not empty |
| half_full | output | 1 | Queue holds 16 or more words |
| full | output | 1 | Queue holds 32 words |

## Verification
The hardest cases to reach from the ports are the ones that mix reception with table handling. One is a word cut off partway through by a rise of `lbl_load`. Another is a stale table slot that must no longer match after a shorter reload. To reach them, the bench forks a word transmission and raises the load input in the middle of it. It also reloads three labels and then sends a word whose label sits only in slot 5 from the earlier load. The full and overflow cases come from a sweep of 33 words with arithmetically generated contents. That sweep checks the flags after every word, and then drains the queue in order.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;

  typedef enum logic [1:0] {
    LV_NULL = 2'd0,
    LV_ZERO = 2'd1,
    LV_ONE  = 2'd2,
    LV_BAD  = 2'd3
  } line_lvl_e;

  localparam int WORD_W  = 32;
  localparam int LABEL_W = 8;

  function automatic line_lvl_e classify(input logic hi, input logic lo);
    line_lvl_e v;
    case ({hi, lo})
      2'b10:   v = LV_ONE;
      2'b01:   v = LV_ZERO;
      2'b11:   v = LV_BAD;
      default: v = LV_NULL;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/a429_bit_rx.sv
module a429_bit_rx
  import a429_rx_pkg::*;
#(
  parameter int FAST_CLKS = 10,
  parameter int SLOW_CLKS = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_hi,
  input  logic              line_lo,
  input  logic              rate_slow,
  input  logic              suspend,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);

  localparam int CW  = $clog2(SLOW_CLKS * 2);
  localparam int NBW = $clog2(WORD_W + 1);

  line_lvl_e         lvl;
  logic [CW-1:0]     bit_clks, samp_at, gap_at;
  logic              bit_start;

  logic              prev_null_q, prev_null_d;
  logic              active_q, active_d;
  logic              err_q, err_d;
  logic              vld_q, vld_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [NBW-1:0]    nbits_q, nbits_d;
  logic [WORD_W-1:0] sh_q, sh_d;

  assign lvl       = classify(line_hi, line_lo);
  assign bit_clks  = rate_slow ? CW'(SLOW_CLKS) : CW'(FAST_CLKS);
  assign samp_at   = bit_clks >> 2;
  assign gap_at    = bit_clks + (bit_clks >> 1);
  assign bit_start = prev_null_q && (lvl != LV_NULL);

  always_comb begin
    prev_null_d = prev_null_q;
    active_d    = active_q;
    err_d       = err_q;
    cnt_d       = cnt_q;
    nbits_d     = nbits_q;
    sh_d        = sh_q;
    vld_d       = 1'b0;
    if (suspend) begin
      prev_null_d = 1'b0;
      active_d    = 1'b0;
      err_d       = 1'b0;
      cnt_d       = '0;
      nbits_d     = '0;
    end else begin
      prev_null_d = (lvl == LV_NULL);
      if (bit_start) begin
        active_d = 1'b1;
        cnt_d    = '0;
      end else if (active_q) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == samp_at) begin
          if ((lvl == LV_ONE) || (lvl == LV_ZERO)) begin
            if (nbits_q == NBW'(WORD_W)) begin
              err_d = 1'b1;
            end else begin
              sh_d    = {(lvl == LV_ONE), sh_q[WORD_W-1:1]};
              nbits_d = nbits_q + 1'b1;
            end
          end else begin
            err_d = 1'b1;
          end
        end
        if (cnt_q == gap_at) begin
          vld_d    = (nbits_q == NBW'(WORD_W)) && !err_q;
          active_d = 1'b0;
          err_d    = 1'b0;
          nbits_d  = '0;
          cnt_d    = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_null_q <= 1'b0;
      active_q    <= 1'b0;
      err_q       <= 1'b0;
      vld_q       <= 1'b0;
      cnt_q       <= '0;
      nbits_q     <= '0;
      sh_q        <= '0;
    end else begin
      prev_null_q <= prev_null_d;
      active_q    <= active_d;
      err_q       <= err_d;
      vld_q       <= vld_d;
      cnt_q       <= cnt_d;
      nbits_q     <= nbits_d;
      sh_q        <= sh_d;
    end
  end

  assign word_vld = vld_q;
  assign word     = sh_q;

endmodule

// File: rtl/a429_lbl_table.sv
module a429_lbl_table
  import a429_rx_pkg::*;
#(
  parameter int N_LABELS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic                        wr,
  input  logic [LABEL_W-1:0]          wr_lbl,
  input  logic [LABEL_W-1:0]          cmp_lbl,
  input  logic [$clog2(N_LABELS)-1:0] rd_idx,
  output logic                        hit,
  output logic [LABEL_W-1:0]          rd_lbl
);

  localparam int IW  = $clog2(N_LABELS);
  localparam int NUW = $clog2(N_LABELS + 1);

  logic [LABEL_W-1:0] mem_q [N_LABELS];
  logic               load_q;
  logic [NUW-1:0]     used_q, used_d, wptr;
  logic               load_rise, we;
  logic [N_LABELS-1:0] hit_vec;

  assign load_rise = load && !load_q;
  assign wptr      = load_rise ? '0 : used_q;
  assign we        = load && wr && (wptr < NUW'(N_LABELS));
  assign used_d    = we ? (wptr + 1'b1) : wptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      used_q <= '0;
      for (int i = 0; i < N_LABELS; i++) mem_q[i] <= '0;
    end else begin
      load_q <= load;
      used_q <= used_d;
      if (we) mem_q[wptr[IW-1:0]] <= wr_lbl;
    end
  end

  for (genvar g = 0; g < N_LABELS; g++) begin : g_cmp
    assign hit_vec[g] = (NUW'(g) < used_q) && (mem_q[g] == cmp_lbl);
  end

  assign hit    = |hit_vec;
  assign rd_lbl = mem_q[rd_idx];

endmodule

// File: rtl/a429_fifo.sv
module a429_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DW-1:0]              din,
  input  logic                       pop,
  output logic [DW-1:0]              dout,
  output logic [$clog2(DEPTH+1)-1:0] fill
);

  localparam int AW = $clog2(DEPTH);
  localparam int FW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [FW-1:0] fill_q, fill_d;
  logic          do_push, do_pop;

  assign do_push = push && (fill_q != FW'(DEPTH));
  assign do_pop  = pop && (fill_q != '0);

  always_comb begin
    wp_d   = do_push ? wp_q + 1'b1 : wp_q;
    rp_d   = do_pop  ? rp_q + 1'b1 : rp_q;
    fill_d = fill_q;
    if (do_push && !do_pop) fill_d = fill_q + 1'b1;
    if (do_pop && !do_push) fill_d = fill_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= din;
  end

  assign dout = mem_q[rp_q];
  assign fill = fill_q;

endmodule

// File: rtl/a429_rx_filter.sv
module a429_rx_filter
  import a429_rx_pkg::*;
#(
  parameter int FAST_BIT_CLKS = 10,
  parameter int SLOW_BIT_CLKS = 80,
  parameter int FIFO_DEPTH    = 32,
  parameter int N_LABELS      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_hi,
  input  logic        line_lo,
  input  logic        rate_slow,
  input  logic        filt_en,
  input  logic        lbl_load,
  input  logic        lbl_wr,
  input  logic [7:0]  lbl_wdata,
  input  logic        lbl_dump,
  input  logic        rd_stb,
  output logic [15:0] rd_data,
  output logic        data_rdy,
  output logic        half_full,
  output logic        full
);

  localparam int BUS_W  = WORD_W / 2;
  localparam int FILL_W = $clog2(FIFO_DEPTH + 1);
  localparam int DCW    = $clog2(N_LABELS + 1);
  localparam int LIW    = $clog2(N_LABELS);

  logic              word_vld, lbl_hit, accept, dumping, pop, host_rd;
  logic [WORD_W-1:0] word, head;
  logic [FILL_W-1:0] fill;
  logic [LABEL_W-1:0] rd_lbl;
  logic [LIW-1:0]    dump_idx;
  logic              upper_q, upper_d;
  logic [DCW-1:0]    dump_q, dump_d;

  a429_bit_rx #(
    .FAST_CLKS(FAST_BIT_CLKS),
    .SLOW_CLKS(SLOW_BIT_CLKS)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_hi  (line_hi),
    .line_lo  (line_lo),
    .rate_slow(rate_slow),
    .suspend  (lbl_load),
    .word_vld (word_vld),
    .word     (word)
  );

  a429_lbl_table #(
    .N_LABELS(N_LABELS)
  ) u_tbl (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (lbl_load),
    .wr     (lbl_wr),
    .wr_lbl (lbl_wdata),
    .cmp_lbl(word[LABEL_W-1:0]),
    .rd_idx (dump_idx),
    .hit    (lbl_hit),
    .rd_lbl (rd_lbl)
  );

  assign accept = word_vld && (!filt_en || lbl_hit) && (fill != FILL_W'(FIFO_DEPTH));

  a429_fifo #(
    .DW   (WORD_W),
    .DEPTH(FIFO_DEPTH)
  ) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (accept),
    .din  (word),
    .pop  (pop),
    .dout (head),
    .fill (fill)
  );

  assign dumping  = (dump_q != '0);
  assign dump_idx = LIW'(N_LABELS - int'(dump_q));
  assign host_rd  = rd_stb && !lbl_dump && !dumping && (fill != '0);
  assign pop      = host_rd && upper_q;

  always_comb begin
    upper_d = upper_q;
    dump_d  = dump_q;
    if (lbl_dump) begin
      dump_d = DCW'(N_LABELS);
    end else if (rd_stb && dumping) begin
      dump_d = dump_q - 1'b1;
    end
    if (host_rd) upper_d = !upper_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= 1'b0;
      dump_q  <= '0;
    end else begin
      upper_q <= upper_d;
      dump_q  <= dump_d;
    end
  end

  assign rd_data   = dumping ? {{(BUS_W-LABEL_W){1'b0}}, rd_lbl}
                             : (upper_q ? head[WORD_W-1:BUS_W] : head[BUS_W-1:0]);
  assign data_rdy  = (fill != '0);
  assign half_full = (fill >= FILL_W'(FIFO_DEPTH / 2));
  assign full      = (fill == FILL_W'(FIFO_DEPTH));

endmodule

// File: rtl/a429_rx_chk.sv
module a429_rx_chk #(
  parameter int FIFO_DEPTH = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            lbl_load,
  input logic                            rd_stb,
  input logic                            word_vld,
  input logic                            accept,
  input logic                            dumping,
  input logic                            data_rdy,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fill
);

  localparam int FW = $clog2(FIFO_DEPTH + 1);

  AST_SUSPEND_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    lbl_load |=> !word_vld); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == FW'(FIFO_DEPTH) && !rd_stb) |=> (fill == FW'(FIFO_DEPTH))); // R9

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((fill == $past(fill)) || (fill == $past(fill) + 1'b1)
              || (fill == $past(fill) - 1'b1))); // R9

  AST_DUMP_KEEPS_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    (dumping && rd_stb && !accept) |=> (fill == $past(fill))); // R7

  AST_READY_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> data_rdy); // R10

endmodule

bind a429_rx_filter a429_rx_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .lbl_load(lbl_load),
  .rd_stb  (rd_stb),
  .word_vld(word_vld),
  .accept  (accept),
  .dumping (dumping),
  .data_rdy(data_rdy),
  .fill    (fill)
);

// File: tb/a429_rx_filter_test.sv
`timescale 1ns/1ps
module a429_rx_filter_test;

  logic clk = 1'b0;
  logic rst_n;
  logic line_hi, line_lo, rate_slow, filt_en;
  logic lbl_load, lbl_wr, lbl_dump, rd_stb;
  logic [7:0]  lbl_wdata;
  logic [15:0] rd_data;
  logic data_rdy, half_full, full;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  a429_rx_filter uut (
    .clk(clk), .rst_n(rst_n), .line_hi(line_hi), .line_lo(line_lo),
    .rate_slow(rate_slow), .filt_en(filt_en), .lbl_load(lbl_load),
    .lbl_wr(lbl_wr), .lbl_wdata(lbl_wdata), .lbl_dump(lbl_dump),
    .rd_stb(rd_stb), .rd_data(rd_data), .data_rdy(data_rdy),
    .half_full(half_full), .full(full)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int k);
    return 32'(32'h9E3779B9 * (k + 1)) ^ 32'(k);
  endfunction

  function automatic logic [7:0] lab(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  task automatic send_word(input logic [31:0] w, input int nb, input int bad_bit);
    int bc = rate_slow ? 80 : 10;
    for (int i = 0; i < nb; i++) begin
      if (i == bad_bit) begin
        line_hi = 1'b1; line_lo = 1'b1;
      end else begin
        line_hi = w[i % 32]; line_lo = !w[i % 32];
      end
      repeat (bc / 2) @(negedge clk);
      line_hi = 1'b0; line_lo = 1'b0;
      repeat (bc / 2) @(negedge clk);
    end
    repeat (4 * bc) @(negedge clk);
  endtask

  task automatic strobe_rd();
    rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0; @(negedge clk);
  endtask

  task automatic read_word(output logic [31:0] w);
    logic [15:0] lo;
    lo = rd_data;
    strobe_rd();
    w = {rd_data, lo};
    strobe_rd();
  endtask

  task automatic load_labels(input int n, input int base_sel);
    lbl_load = 1'b1; @(negedge clk);
    for (int k = 0; k < n; k++) begin
      lbl_wdata = (base_sel == 0) ? lab(k) : ((k == 0) ? 8'hA1 : (k == 1) ? 8'h35 : 8'h7E);
      lbl_wr = 1'b1; @(negedge clk);
      lbl_wr = 1'b0; @(negedge clk);
    end
    lbl_load = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    rst_n = 1'b0; line_hi = 0; line_lo = 0; rate_slow = 0; filt_en = 0;
    lbl_load = 0; lbl_wr = 0; lbl_wdata = 0; lbl_dump = 0; rd_stb = 0;
    repeat (3) @(negedge clk);
    chk("R1 data_rdy", 32'(data_rdy), 0);
    chk("R1 half_full", 32'(half_full), 0);
    chk("R1 full", 32'(full), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: read on empty queue is ignored
    strobe_rd();
    send_word(32'h6B3C01A5, 32, -1);
    send_word(32'h80000001, 32, -1);
    send_word(32'h123456FF, 32, -1);
    chk("R10 data_rdy after words", 32'(data_rdy), 1);
    chk("R8 low half first", 32'(rd_data), 32'h01A5);
    read_word(w); chk("R2 R3 word A", w, 32'h6B3C01A5);
    read_word(w); chk("R2 word B", w, 32'h80000001);
    read_word(w); chk("R9 word C order", w, 32'h123456FF);
    chk("R10 empty after reads", 32'(data_rdy), 0);

    rate_slow = 1'b1;
    send_word(32'hC0DE5A5A, 32, -1);
    read_word(w); chk("R2 slow rate word", w, 32'hC0DE5A5A);
    rate_slow = 1'b0;

    send_word(32'h5555AAAA, 32, 7);
    chk("R4 both-high bit dropped", 32'(data_rdy), 0);
    send_word(32'h5555AAAA, 20, -1);
    chk("R4 short word dropped", 32'(data_rdy), 0);
    send_word(32'h5555AAAA, 33, -1);
    chk("R4 33-bit word dropped", 32'(data_rdy), 0);

    // R6 / R7: 17 writes, 17th ignored; dump does not pop
    load_labels(17, 0);
    send_word(32'hFEED0042, 32, -1);
    lbl_dump = 1'b1; @(negedge clk); lbl_dump = 1'b0; @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      chk("R7 R6 label readback", 32'(rd_data), {24'h0, lab(k)});
      strobe_rd();
    end
    read_word(w); chk("R7 queue kept through dump", w, 32'hFEED0042);

    filt_en = 1'b1;
    send_word({24'h777777, lab(16)}, 32, -1);
    chk("R5 unknown label dropped", 32'(data_rdy), 0);
    send_word({24'h333333, lab(4)}, 32, -1);
    read_word(w); chk("R5 table label kept", w, {24'h333333, lab(4)});

    load_labels(3, 1);
    send_word(32'h000001A1, 32, -1);
    send_word(32'h00000222, 32, -1);
    send_word({24'h000003, lab(5)}, 32, -1);
    send_word(32'h0000047E, 32, -1);
    read_word(w); chk("R5 first match", w, 32'h000001A1);
    read_word(w); chk("R5 R6 stale slot ignored", w, 32'h0000047E);
    chk("R5 nothing else stored", 32'(data_rdy), 0);
    lbl_dump = 1'b1; @(negedge clk); lbl_dump = 1'b0; @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      chk("R6 reload order", 32'(rd_data),
          {24'h0, (k == 0) ? 8'hA1 : (k == 1) ? 8'h35 : (k == 2) ? 8'h7E : lab(k)});
      strobe_rd();
    end

    filt_en = 1'b0;
    lbl_load = 1'b1; @(negedge clk);
    send_word(32'hABCDEF01, 32, -1);
    lbl_load = 1'b0; @(negedge clk);
    chk("R6 word during load dropped", 32'(data_rdy), 0);
    fork
      send_word(32'h13579BDF, 32, -1);
      begin
        repeat (100) @(negedge clk);
        lbl_load = 1'b1; repeat (2) @(negedge clk); lbl_load = 1'b0;
      end
    join
    chk("R6 word cut by load dropped", 32'(data_rdy), 0);
    send_word(32'h2468ACE0, 32, -1);
    read_word(w); chk("R3 recovery after suspend", w, 32'h2468ACE0);

    for (int k = 0; k < 33; k++) begin
      send_word(pat(k), 32, -1);
      chk("R10 half_full sweep", 32'(half_full), 32'(k + 1 >= 16));
      chk("R10 full sweep", 32'(full), 32'(k + 1 >= 32));
    end
    for (int k = 0; k < 32; k++) begin
      read_word(w);
      chk("R9 fifo order", w, pat(k));
      chk("R10 full after read", 32'(full), 0);
    end
    chk("R9 33rd word dropped", 32'(data_rdy), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule